// File: doc/BRIEF.md
# FIFO Port Access Decoder

This block decodes the control pins of one port of a buffer that holds two FIFOs, one for each direction. The port shares a single data bus between writing into the outbound FIFO and reading from the inbound FIFO. From a chip select, a direction select, an enable and a mailbox select, the decoder produces three outputs:
- an output enable that puts the inbound FIFO's read data onto the shared bus;
- a push strobe into the outbound FIFO;
- a pop strobe from the inbound FIFO.

Each strobe is qualified by the flag of the FIFO it touches: the space-available flag for a push, the data-available flag for a pop.

The strobes are purely combinational. The FIFO samples them on its port clock edge. The output enable is independent of any clock.

The same module serves both ports of the buffer. The parameter `INVERT_DIR` reverses the meaning of the direction select, so the second port drives its bus when the select is high and pushes when it is low. While mailbox select is high, both strobes are held off so that a separate mailbox path can use the cycle. Two instances of the decoder share no state.

Top module: `fifo_port_decoder`

## Requirements
- R1: With `INVERT_DIR`=0, `bus` carries `rd_data` and `bus_oe` is 1 exactly when `cs_n`=0 and `dir_sel`=0. Otherwise `bus_oe` is 0 and `bus` is high-impedance.
- R2: With `INVERT_DIR`=1, `bus` carries `rd_data` and `bus_oe` is 1 exactly when `cs_n`=0 and `dir_sel`=1.
- R3: With `INVERT_DIR`=0, `push` is 1 exactly when `cs_n`=0, `dir_sel`=1, `en`=1, `mbx_sel`=0 and `space_ok`=1.
- R4: With `INVERT_DIR`=0, `pop` is 1 exactly when `cs_n`=0, `dir_sel`=0, `en`=1, `mbx_sel`=0 and `avail_ok`=1.
- R5: With `INVERT_DIR`=1, `push` requires `dir_sel`=0 and `pop` requires `dir_sel`=1. All other conditions are the same as in R3 and R4.
- R6: While `en`=0, `push` and `pop` stay 0 whatever `cs_n` and `dir_sel` do.
- R7: While `mbx_sel`=1, `push` and `pop` stay 0.
- R8: `bus_oe` depends only on `cs_n` and `dir_sel`. It is unaffected by `en`, `mbx_sel` and both flags.
- R9: Two instances operate independently. Holding one port's inputs constant keeps its outputs constant while the other port's inputs change.
- R10: `wr_data` always equals the value on `bus`, whether the bus is driven by an external agent or by the decoder itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Port chip select, active low |
| dir_sel | input | 1 | Direction select; meaning set by INVERT_DIR |
| en | input | 1 | Port enable; no strobe while low |
| mbx_sel | input | 1 | Mailbox cycle select; suppresses FIFO strobes |
| space_ok | input | 1 | Outbound FIFO has room (full/input-ready flag) |
| avail_ok | input | 1 | Inbound FIFO has a word (empty/output-ready flag) |
| rd_data | input | W | Inbound FIFO output word |
| bus | inout | W | Shared bidirectional data bus |
| wr_data | output | W | Word presented to the outbound FIFO |
| bus_oe | output | 1 | Decoder is driving the bus |
| push | output | 1 | Write strobe into the outbound FIFO |
| pop | output | 1 | Read strobe from the inbound FIFO |

## Verification
The bench builds two instances side by side:
- an 8-bit port with `INVERT_DIR`=0;
- a 12-bit port with `INVERT_DIR`=1.

Both direction polarities and two bus widths are therefore covered in the same run. Every combination of the six control and flag inputs is applied to each port. In one phase, one port is held in a steady push state while the other sweeps all of its combinations, which exposes any coupling between the ports. A pseudo-random sequence then mixes bus values so that the data-path checks on `wr_data` and on the driven bus see varied words.

// File: rtl/fifo_port_decoder.sv
module fifo_port_decoder #(
  parameter int W          = 36,
  parameter bit INVERT_DIR = 1'b0
) (
  input  logic         cs_n,
  input  logic         dir_sel,
  input  logic         en,
  input  logic         mbx_sel,
  input  logic         space_ok,
  input  logic         avail_ok,
  input  logic [W-1:0] rd_data,
  inout  wire  [W-1:0] bus,
  output logic [W-1:0] wr_data,
  output logic         bus_oe,
  output logic         push,
  output logic         pop
);

  logic toward_fifo;
  logic fifo_cycle;

  assign toward_fifo = INVERT_DIR ? ~dir_sel : dir_sel;
  assign fifo_cycle  = ~cs_n & en & ~mbx_sel;

  assign bus_oe  = ~cs_n & ~toward_fifo;
  assign push    = fifo_cycle & toward_fifo & space_ok;
  assign pop     = fifo_cycle & ~toward_fifo & avail_ok;

  assign bus     = bus_oe ? rd_data : {W{1'bz}};
  assign wr_data = bus;

endmodule

module fifo_port_decoder_chk (
  input logic cs_n,
  input logic en,
  input logic mbx_sel,
  input logic space_ok,
  input logic avail_ok,
  input logic bus_oe,
  input logic push,
  input logic pop
);

  always_comb begin
    // R3
    push_excl_pop_chk: assert (!(push && pop));
    // R1
    oe_needs_cs_chk: assert (!bus_oe || !cs_n);
    // R4
    pop_drives_bus_chk: assert (!pop || bus_oe);
    // R3
    push_not_while_oe_chk: assert (!push || !bus_oe);
    // R6
    en_gates_strobe_chk: assert (en || (!push && !pop));
    // R7
    mbx_gates_strobe_chk: assert (!mbx_sel || (!push && !pop));
    // R5
    push_flag_chk: assert (!push || space_ok);
    // R5
    pop_flag_chk: assert (!pop || avail_ok);
  end

endmodule

bind fifo_port_decoder fifo_port_decoder_chk u_chk (
  .cs_n(cs_n), .en(en), .mbx_sel(mbx_sel), .space_ok(space_ok),
  .avail_ok(avail_ok), .bus_oe(bus_oe), .push(push), .pop(pop)
);

// File: tb/fifo_port_decoder_bench.sv
module fifo_port_decoder_bench;
  localparam int WA = 8;
  localparam int WB = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0]    va = 6'b000001, vb = 6'b000001;
  logic [WA-1:0] a_rd = '0, a_tv = '0;
  logic [WB-1:0] b_rd = '0, b_tv = '0;
  logic          a_td = 1'b0, b_td = 1'b0;
  wire  [WA-1:0] a_bus;
  wire  [WB-1:0] b_bus;
  logic [WA-1:0] a_wd;
  logic [WB-1:0] b_wd;
  logic a_oe, a_push, a_pop, b_oe, b_push, b_pop;

  assign a_bus = a_td ? a_tv : {WA{1'bz}};
  assign b_bus = b_td ? b_tv : {WB{1'bz}};

  fifo_port_decoder #(.W(WA), .INVERT_DIR(1'b0)) u_fifo_port_decoder (
    .cs_n(va[0]), .dir_sel(va[1]), .en(va[2]), .mbx_sel(va[3]),
    .space_ok(va[4]), .avail_ok(va[5]), .rd_data(a_rd), .bus(a_bus),
    .wr_data(a_wd), .bus_oe(a_oe), .push(a_push), .pop(a_pop));

  fifo_port_decoder #(.W(WB), .INVERT_DIR(1'b1)) u_fifo_port_decoder_b (
    .cs_n(vb[0]), .dir_sel(vb[1]), .en(vb[2]), .mbx_sel(vb[3]),
    .space_ok(vb[4]), .avail_ok(vb[5]), .rd_data(b_rd), .bus(b_bus),
    .wr_data(b_wd), .bus_oe(b_oe), .push(b_push), .pop(b_pop));

  typedef struct {
    logic oe, push, pop, hiz;
    logic [15:0] val;
    string t_oe, t_st, t_bus;
  } exp_t;

  exp_t qa[$];
  exp_t qb[$];

  function automatic exp_t model(input logic [5:0] v, input bit inv,
                                 input logic [15:0] rd, input logic [15:0] tv,
                                 input bit indep);
    exp_t e;
    logic tw;
    tw = inv ? ~v[1] : v[1];
    e.oe   = !v[0] && !tw;
    e.push = !v[0] && tw && v[2] && !v[3] && v[4];
    e.pop  = !v[0] && !tw && v[2] && !v[3] && v[5];
    e.hiz  = 1'b0;
    e.val  = e.oe ? rd : tv;
    if (!v[2])      e.t_st = "R6";
    else if (v[3])  e.t_st = "R7";
    else if (inv)   e.t_st = "R5";
    else            e.t_st = e.oe ? "R4" : "R3";
    if (!v[2] || v[3]) e.t_oe = "R8";
    else               e.t_oe = inv ? "R2" : "R1";
    e.t_bus = "R10";
    if (indep) begin
      e.t_oe = "R9"; e.t_st = "R9"; e.t_bus = "R9";
    end
    return e;
  endfunction

  task automatic step(input logic [5:0] nva, input logic [5:0] nvb,
                      input logic [15:0] ra, input logic [15:0] rb,
                      input bit hiz_a, input bit indep_b);
    exp_t ea, eb;
    @(posedge clk);
    va = nva; vb = nvb;
    a_rd = ra[WA-1:0]; b_rd = rb[WB-1:0];
    a_tv = rb[WA-1:0]; b_tv = ra[WB-1:0];
    ea = model(nva, 1'b0, {8'h0, a_rd}, {8'h0, a_tv}, 1'b0);
    eb = model(nvb, 1'b1, {4'h0, b_rd}, {4'h0, b_tv}, indep_b);
    a_td = !ea.oe && !hiz_a;
    b_td = !eb.oe;
    ea.hiz = !ea.oe && hiz_a;
    qa.push_back(ea);
    qb.push_back(eb);
  endtask

  task automatic chk1(input string tag, input string what,
                      input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  task automatic chkw(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (qa.size() > 0) begin
        exp_t e;
        e = qa.pop_front();
        chk1(e.t_oe, "A bus_oe", a_oe, e.oe);
        chk1(e.t_st, "A push", a_push, e.push);
        chk1(e.t_st, "A pop", a_pop, e.pop);
        if (e.hiz) begin
          checks++;
          if (a_bus !== {WA{1'bz}}) begin
            errors++;
            $display("FAIL R1 A bus not released act=%h exp=z", a_bus);
          end
        end else begin
          chkw(e.t_bus, "A wr_data", {8'h0, a_wd}, e.val);
        end
      end
      while (qb.size() > 0) begin
        exp_t e;
        e = qb.pop_front();
        chk1(e.t_oe, "B bus_oe", b_oe, e.oe);
        chk1(e.t_st, "B push", b_push, e.push);
        chk1(e.t_st, "B pop", b_pop, e.pop);
        chkw(e.t_bus, "B wr_data", {4'h0, b_wd}, e.val);
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    // idle state: deselected, nothing driven, no strobes (R1, R6)
    step(6'b000001, 6'b000001, 16'h0055, 16'h0AA0, 1'b1, 1'b0);
    // full sweep on both ports with opposite patterns (R1..R8)
    for (int i = 0; i < 64; i++)
      step(i[5:0], 6'(63 - i), 16'(i * 37), 16'(i * 91 + 5), i[6], 1'b0);
    // sweep with released bus on A (R1 high-impedance)
    for (int i = 0; i < 64; i++)
      step(i[5:0], 6'(i), 16'(i + 3), 16'(i * 7), 1'b1, 1'b0);
    // R9: B held in a push state while A sweeps
    for (int i = 0; i < 64; i++)
      step(i[5:0], 6'b010100, 16'(i * 13), 16'h0321, 1'b0, 1'b1);
    // pseudo-random mix (R10 data path, R3, R4, R5)
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[5:0], lfsr[11:6], lfsr, {lfsr[7:0], lfsr[15:8]}, lfsr[12], 1'b0);
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired act=running exp=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule